// File: doc/BRIEF.md
# Dual-Bus Ready Synchroniser

This block merges the transfer-complete indications of two system buses into one ready signal for the processor. Each bus supplies a ready input and an active-low address enable; a ready input counts only while its own enable is low. Any enabled source may raise the merged result, and the registered output tells the processor that it may finish the pending transfer.

The processor clock is not used as a clock here. Its rising and falling edges arrive as one-cycle strobes inside a single fast clock domain. A mode input picks the depth of synchronisation for each bus cycle. In the deep mode, a ready that turns on passes through a first flop on a rising strobe and then through a second flop on the next falling strobe. A ready that turns off goes straight to the second flop. In the shallow mode, the first flop is skipped and only the falling strobe samples the merged ready. On the board, a pull-up holds the mode input high when nothing drives it.

Top module: `dual_ready_sync`

## Requirements
- R1: Bit i of `bus_rdy` counts only while bit i of `bus_aen_n` is 0. A source whose enable bit is 1 cannot set `ready`.
- R2: The qualified sources are ORed, so one enabled source alone is enough to set `ready` (bus 0 is bit 0, bus 1 is bit 1).
- R3: With `async_sel` = 0, a qualified ready that turns on sets `ready` only at a falling strobe that follows a rising strobe which already saw it as 1. A ready that first appears between a rising and a falling strobe leaves `ready` at 0 at that falling strobe.
- R4: With `async_sel` = 0, `ready` clears at the first falling strobe where no qualified source is 1, whatever the first flop holds.
- R5: With `async_sel` = 1, each falling strobe loads `ready` with the merged qualified input, and the first flop plays no part.
- R6: The value of `async_sel` at the falling strobe decides which path applies at that strobe. Its value at the preceding rising strobe has no effect.
- R7: `ready` changes only on the fast-clock cycle after a cycle in which `pclk_fall` is 1.
- R8: While `rst_n` is 0, `ready` is 0 and the first flop is cleared. After reset, a deep-mode falling strobe that comes before any rising strobe leaves `ready` at 0.
- R9: An undriven `async_sel` is pulled high on the board, and the block then behaves as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pclk_rise | input | 1 | One-cycle strobe marking a processor clock rising edge |
| pclk_fall | input | 1 | One-cycle strobe marking a processor clock falling edge |
| bus_rdy | input | NUM_BUS | Ready input of each bus, active high |
| bus_aen_n | input | NUM_BUS | Active-low enable that qualifies each bus ready |
| async_sel | input | 1 | 0 selects two synchronisation stages, 1 selects one stage |
| ready | output | 1 | Registered merged ready to the processor |

## Verification
The bench targets a ready that appears between a rising and a falling strobe in deep mode. A design that skipped the first flop would raise `ready` one processor cycle early. Dropping a source after the first flop has captured it checks that release bypasses that flop; a design that routed release through the flop would hold `ready` one cycle too long. Changing the mode between the two strobes, releasing the mode input to its pull-up, and asserting reset while the first flop is set each catch a wrongly timed mode sample or a stale first-flop value. Masked sources and the between-strobe stability of `ready` catch broken qualification and updates at the wrong strobe.

// File: rtl/rdysync_pkg.sv
package rdysync_pkg;
    typedef struct packed {
        logic stage1;
    } cap_state_t;

    typedef struct packed {
        logic ready;
    } rel_state_t;
endpackage

// File: rtl/rdysync_qualify.sv
module rdysync_qualify #(
    parameter int NUM_BUS = 2
) (
    input  logic [NUM_BUS-1:0] rdy,
    input  logic [NUM_BUS-1:0] aen_n,
    output logic               any_qual
);
    logic [NUM_BUS-1:0] qual;

    // Each source counts only while its own enable is low.
    for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus
        assign qual[g] = rdy[g] & ~aen_n[g];
    end

    assign any_qual = |qual;
endmodule

// File: rtl/rdysync_capture.sv
module rdysync_capture
    import rdysync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise_stb,
    input  logic qual_in,
    output logic stage1
);
    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rise_stb) begin
            st_d.stage1 = qual_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage1 = st_q.stage1;
endmodule

// File: rtl/rdysync_release.sv
module rdysync_release
    import rdysync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall_stb,
    input  logic async_sel,
    input  logic qual_in,
    input  logic stage1,
    output logic ready
);
    rel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fall_stb) begin
            if (async_sel) begin
                // single stage: the merged input goes straight in
                st_d.ready = qual_in;
            end else begin
                // two stages for assertion; release skips the first flop
                st_d.ready = qual_in & stage1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = st_q.ready;
endmodule

// File: rtl/dual_ready_sync.sv
module dual_ready_sync #(
    parameter int NUM_BUS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pclk_rise,
    input  logic               pclk_fall,
    input  logic [NUM_BUS-1:0] bus_rdy,
    input  logic [NUM_BUS-1:0] bus_aen_n,
    input  logic               async_sel,
    output logic               ready
);
    logic any_qual;
    logic stage1;

    rdysync_qualify #(.NUM_BUS(NUM_BUS)) u_qual (
        .rdy      (bus_rdy),
        .aen_n    (bus_aen_n),
        .any_qual (any_qual)
    );

    rdysync_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_stb (pclk_rise),
        .qual_in  (any_qual),
        .stage1   (stage1)
    );

    rdysync_release u_rel (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_stb  (pclk_fall),
        .async_sel (async_sel),
        .qual_in   (any_qual),
        .stage1    (stage1),
        .ready     (ready)
    );
endmodule

// File: rtl/dual_ready_sync_chk.sv
module dual_ready_sync_chk #(
    parameter int NUM_BUS = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pclk_rise,
    input logic               pclk_fall,
    input logic [NUM_BUS-1:0] bus_rdy,
    input logic [NUM_BUS-1:0] bus_aen_n,
    input logic               async_sel,
    input logic               ready
);
    logic none_enabled;
    logic port_qual;
    assign none_enabled = &bus_aen_n;
    assign port_qual    = |(bus_rdy & ~bus_aen_n);

    // R8: output is low on the first edge after reset ends
    a_r8_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !ready);

    // R7: no falling strobe, no change
    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !pclk_fall |=> $stable(ready));

    // R1: with every enable high the output cannot be set
    a_r1_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (pclk_fall && none_enabled) |=> !ready);

    // R4: release at a falling strobe with no qualified source
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pclk_fall && !port_qual) |=> !ready);

    // R5: single-stage path follows the input directly
    a_r5_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (pclk_fall && async_sel && port_qual) |=> ready);
endmodule

bind dual_ready_sync dual_ready_sync_chk #(.NUM_BUS(NUM_BUS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pclk_rise (pclk_rise),
    .pclk_fall (pclk_fall),
    .bus_rdy   (bus_rdy),
    .bus_aen_n (bus_aen_n),
    .async_sel (async_sel),
    .ready     (ready)
);

// File: tb/dual_ready_sync_tb.sv
module dual_ready_sync_tb;
    localparam int NB = 2;

    typedef struct {
        bit    exp;
        string tag;
    } exp_item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pclk_rise = 1'b0;
    logic          pclk_fall = 1'b0;
    logic [NB-1:0] bus_rdy = '0;
    logic [NB-1:0] bus_aen_n = '1;
    logic          as_drive_en = 1'b1;
    logic          as_drive_val = 1'b1;
    logic          async_sel;
    logic          ready;

    // board pull-up on the mode input
    assign async_sel = as_drive_en ? as_drive_val : 1'b1;

    int total = 0;
    int bad = 0;
    bit m_s1 = 1'b0;
    bit pend = 1'b0;
    bit last_ready = 1'b0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    int cyc = 0;
    exp_item_t q_exp[$];

    always #4 clk = ~clk;

    dual_ready_sync #(.NUM_BUS(NB)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pclk_rise (pclk_rise),
        .pclk_fall (pclk_fall),
        .bus_rdy   (bus_rdy),
        .bus_aen_n (bus_aen_n),
        .async_sel (async_sel),
        .ready     (ready)
    );

    task automatic check(input bit act, input bit exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: ready=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // One processor cycle: rising strobe with one input set, falling
    // strobe with another, expected output queued for the monitor.
    task automatic pcycle(input logic [NB-1:0] rdy_r, input logic [NB-1:0] aen_r,
                          input logic [NB-1:0] rdy_f, input logic [NB-1:0] aen_f,
                          input bit as_en, input bit as_val, input string tag);
        exp_item_t it;
        bit qf, asy;
        @(negedge clk);
        bus_rdy = rdy_r; bus_aen_n = aen_r; pclk_rise = 1'b1;
        m_s1 = |(rdy_r & ~aen_r);
        @(negedge clk);
        pclk_rise = 1'b0;
        @(negedge clk);
        bus_rdy = rdy_f; bus_aen_n = aen_f;
        as_drive_en = as_en; as_drive_val = as_val;
        pclk_fall = 1'b1;
        qf  = |(rdy_f & ~aen_f);
        asy = as_en ? as_val : 1'b1;
        it.exp = asy ? qf : (qf & m_s1);
        it.tag = tag;
        q_exp.push_back(it);
        @(negedge clk);
        pclk_fall = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // monitor
    always @(posedge clk) pend <= pclk_fall;

    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            if (pend) begin
                if (q_exp.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R7: unexpected update ready=%0b expected=none", ready);
                end else begin
                    exp_item_t it;
                    it = q_exp.pop_front();
                    check(ready, it.exp, it.tag);
                end
            end else begin
                check(ready, last_ready, "R7 stable between strobes");
            end
        end
        last_ready = ready;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: ready=%0b expected=finish", ready);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ready, 1'b0, "R8 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        check(ready, 1'b0, "R8 after reset");
        mon_on = 1'b1;

        // R5 / R2: single stage, bus 0 then release
        pcycle(2'b00, 2'b11, 2'b01, 2'b10, 1, 1, "R5 direct set bus0");
        pcycle(2'b01, 2'b10, 2'b00, 2'b10, 1, 1, "R5 direct clear");
        // R1: enabled bits high mask the sources
        pcycle(2'b11, 2'b11, 2'b01, 2'b01, 1, 1, "R1 bus0 masked");
        pcycle(2'b11, 2'b11, 2'b10, 2'b10, 1, 1, "R1 bus1 masked");
        // R2: bus 1 alone
        pcycle(2'b00, 2'b11, 2'b10, 2'b01, 1, 1, "R2 bus1 alone");
        pcycle(2'b00, 2'b11, 2'b00, 2'b00, 1, 1, "R2 clear");
        // R3: deep mode, late arrival is held back one cycle
        pcycle(2'b00, 2'b00, 2'b01, 2'b00, 1, 0, "R3 late arrival held");
        pcycle(2'b01, 2'b00, 2'b01, 2'b00, 1, 0, "R3 two-stage set");
        // R4: release bypasses the first flop
        pcycle(2'b01, 2'b00, 2'b00, 2'b00, 1, 0, "R4 direct release");
        // R3 with both buses
        pcycle(2'b11, 2'b00, 2'b10, 2'b00, 1, 0, "R3 set via bus1");
        pcycle(2'b00, 2'b00, 2'b00, 2'b00, 1, 0, "R4 release");
        // R6: mode sampled at the falling strobe
        pcycle(2'b00, 2'b00, 2'b01, 2'b00, 1, 1, "R6 async at fall");
        pcycle(2'b00, 2'b00, 2'b00, 2'b00, 1, 0, "R6 clear");
        as_drive_val = 1'b1;
        pcycle(2'b00, 2'b00, 2'b01, 2'b00, 1, 0, "R6 deep at fall");
        // R9: undriven mode input behaves as single stage
        pcycle(2'b00, 2'b00, 2'b01, 2'b00, 0, 0, "R9 pulled high set");
        pcycle(2'b00, 2'b00, 2'b00, 2'b00, 0, 0, "R9 pulled high clear");

        // R8: reset clears a set first flop
        @(negedge clk);
        bus_rdy = 2'b01; bus_aen_n = 2'b00; pclk_rise = 1'b1;
        @(negedge clk);
        pclk_rise = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        m_s1 = 1'b0;
        @(negedge clk);
        check(ready, 1'b0, "R8 ready low in reset");
        rst_n = 1'b1;
        @(negedge clk);
        pcycle_fall_only();

        repeat (4) @(negedge clk);
        if (q_exp.size() != 0) begin
            total++; bad++;
            $display("FAIL R7: pending=%0d expected=0", q_exp.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // falling strobe in deep mode with no rising strobe since reset
    task automatic pcycle_fall_only();
        exp_item_t it;
        @(negedge clk);
        bus_rdy = 2'b01; bus_aen_n = 2'b00;
        as_drive_en = 1'b1; as_drive_val = 1'b0;
        pclk_fall = 1'b1;
        it.exp = 1'b0;
        it.tag = "R8 first flop cleared";
        q_exp.push_back(it);
        @(negedge clk);
        pclk_fall = 1'b0;
        @(negedge clk);
    endtask
endmodule